// File: doc/BRIEF.md
# Sub-rate Time Slot Switch

This block switches PCM data between time slots at 64, 32 or 16 kbit/s. It runs one time slot per clock cycle. A free-running slot counter shows which slot is current on `slotNow`. The incoming byte on `rxByte` is stored in a frame buffer at that slot's position. The frame buffer has two banks that swap at every frame boundary, so each outgoing slot always reads a byte captured during the previous complete frame.

Each outgoing slot has its own control entry. The entry holds a 4-bit connection code, an 8-bit data field and a 2-bit placement value. The data field names the source slot, taken modulo the slot count. The code picks a whole byte, one nibble or one bit pair of the source byte. The placement value decides where that field lands in the outgoing byte, and every bit left over is driven to 1. One code instead sends the data field itself as the outgoing byte; this serves as an idle pattern or a byte supplied by the processor. Control entries are written through a simple single-cycle write port.

The result for the current slot is registered and appears one cycle later on `txByte`, tagged with its slot number on `txSlot`.

Top module: `srs_switch`

## Requirements
- R1: While reset is held and right after it, `txByte` is 8'hFF and `slotNow` and `txSlot` are 0. All control entries clear to code 0000. Both frame buffer banks reset to 8'hFF, so slots read before a full frame has been captured see 8'hFF as the source byte.
- R2: `slotNow` advances by one each cycle, from 0 to NUM_SLOTS-1, and then wraps to 0. The result for the slot shown in cycle n appears on `txSlot`/`txByte` after the clock edge that ends cycle n.
- R3: Codes 0000, 1000 and 1010 through 1111 are unassigned, and the outgoing byte is 8'hFF.
- R4: Code 0001 copies all 8 source bits unchanged. The placement value has no effect.
- R5: Code 0010 takes source bits 3..0 and code 0011 takes source bits 7..4. Placement bit 1 picks the destination nibble (0 = bits 3..0, 1 = bits 7..4). Placement bit 0 has no effect. The other nibble is all ones.
- R6: Codes 0100, 0101, 0110 and 0111 take source bit pair 1..0, 3..2, 5..4 and 7..6 respectively, so the pair is code[1:0]. The placement value p puts the pair at bits 2p+1..2p. All other bits are 1.
- R7: Code 1001 outputs the entry's 8-bit data field as the outgoing byte.
- R8: The source slot is the data field modulo NUM_SLOTS. The source byte is the one captured in that slot during the previous complete frame. The banks swap at the edge that ends slot NUM_SLOTS-1.
- R9: A control write (`cmWe` high) takes effect at the clock edge. A read of that slot in the same cycle still sees the old entry, and reads from the next cycle on see the new one. With `cmWe` low, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one time slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rxByte | input | 8 | Incoming PCM byte for the slot shown on slotNow |
| slotNow | output | SLOT_W | Current slot index |
| cmWe | input | 1 | Control entry write strobe |
| cmAddr | input | SLOT_W | Outgoing slot whose entry is written |
| cmCode | input | 4 | Connection code to write |
| cmData | input | 8 | Data field: source slot pointer, or the direct byte |
| cmPos | input | 2 | Destination placement value |
| txByte | output | 8 | Outgoing byte for slot txSlot |
| txSlot | output | SLOT_W | Slot index of txByte |

## Verification
Some behaviours are checked by assertions on every cycle:
- unassigned slots always leave as all ones;
- a direct slot carries exactly the data field of the cycle before;
- a full-byte slot carries the fetched source byte;
- nibble and pair transfers never clear more than 4 or 2 bits;
- the slot counter steps in order, and the banks swap only when the counter wraps.

Other behaviours can only be shown by the bench scenarios, which compare against a full arithmetic model:
- that the correct source field lands in the correct destination position;
- that the source byte comes from the previous frame and the correct slot after the modulo;
- that a control write is first seen in the cycle after it.

// File: rtl/srs_pkg.sv
package srs_pkg;

  // Kind of transfer chosen by the connection code
  typedef enum logic [2:0] {
    XF_NONE   = 3'd0,
    XF_BYTE   = 3'd1,
    XF_NIB    = 3'd2,
    XF_PAIR   = 3'd3,
    XF_DIRECT = 3'd4
  } xferKind_t;

  // Strobes passed from control to datapath for the current slot
  typedef struct packed {
    xferKind_t  kind;
    logic [1:0] srcField;  // nibble index in bit 0, or pair index
    logic [1:0] dstField;  // nibble index in bit 0, or pair index
    logic [7:0] dataByte;  // direct byte for XF_DIRECT
    logic       wrBank;    // frame buffer bank being filled
  } slotCmd_t;

endpackage

// File: rtl/srs_ctrl.sv
module srs_ctrl
  import srs_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmWe,
  input  logic [SLOT_W-1:0] cmAddr,
  input  logic [3:0]        cmCode,
  input  logic [7:0]        cmData,
  input  logic [1:0]        cmPos,
  output logic [SLOT_W-1:0] slotCnt,
  output logic [SLOT_W-1:0] rdSlot,
  output slotCmd_t          cmd
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  logic [3:0] codeMem [NUM_SLOTS];
  logic [7:0] dataMem [NUM_SLOTS];
  logic [1:0] posMem  [NUM_SLOTS];
  logic       wrBank;

  // Slot counter and bank toggle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slotCnt <= '0;
      wrBank  <= 1'b0;
    end else begin
      if (slotCnt == LAST_SLOT) begin
        slotCnt <= '0;
        wrBank  <= ~wrBank;
      end else begin
        slotCnt <= slotCnt + 1'b1;
      end
    end
  end

  // Control memory, one entry per outgoing slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        codeMem[i] <= 4'b0000;
        dataMem[i] <= 8'h00;
        posMem[i]  <= 2'b00;
      end
    end else if (cmWe) begin
      codeMem[cmAddr] <= cmCode;
      dataMem[cmAddr] <= cmData;
      posMem[cmAddr]  <= cmPos;
    end
  end

  // Code decode for the current slot
  logic [3:0] curCode;
  logic [1:0] curPos;
  logic [7:0] curData;

  always_comb begin
    curCode = codeMem[slotCnt];
    curPos  = posMem[slotCnt];
    curData = dataMem[slotCnt];
    rdSlot  = SLOT_W'(int'(curData) % NUM_SLOTS);

    cmd.kind     = XF_NONE;
    cmd.srcField = 2'b00;
    cmd.dstField = 2'b00;
    cmd.dataByte = curData;
    cmd.wrBank   = wrBank;

    casez (curCode)
      4'b0001: cmd.kind = XF_BYTE;
      4'b001?: begin
        cmd.kind     = XF_NIB;
        cmd.srcField = {1'b0, curCode[0]};
        cmd.dstField = {1'b0, curPos[1]};
      end
      4'b01??: begin
        cmd.kind     = XF_PAIR;
        cmd.srcField = curCode[1:0];
        cmd.dstField = curPos;
      end
      4'b1001: cmd.kind = XF_DIRECT;
      default: cmd.kind = XF_NONE;
    endcase
  end

  // R2
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slotCnt <= LAST_SLOT);

  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slotCnt != LAST_SLOT) |=> (slotCnt == $past(slotCnt) + 1'b1));

  // R8
  bank_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slotCnt == LAST_SLOT) |=> (wrBank != $past(wrBank)));

  // R8
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slotCnt != LAST_SLOT) |=> $stable(wrBank));

endmodule

// File: rtl/srs_datapath.sv
module srs_datapath
  import srs_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slotCmd_t          cmd,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [SLOT_W-1:0] rdSlot,
  input  logic [7:0]        rxByte,
  output logic [7:0]        txByte,
  output logic [SLOT_W-1:0] txSlot
);

  localparam int BANKS = 2;

  logic [7:0] fbuf [BANKS][NUM_SLOTS];
  logic [7:0] srcByte;
  logic [7:0] merged;

  // Frame buffer: one bank fills while the other is read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < BANKS; b++)
        for (int s = 0; s < NUM_SLOTS; s++)
          fbuf[b][s] <= 8'hFF;
    end else begin
      fbuf[cmd.wrBank][wrSlot] <= rxByte;
    end
  end

  assign srcByte = fbuf[~cmd.wrBank][rdSlot];

  // Field extraction and placement; untouched bits stay at 1
  logic [1:0] pairBits;
  logic [3:0] nibBits;
  logic [7:0] pairMask, nibMask;
  logic [7:0] pairVal, nibVal;

  always_comb begin
    pairBits = srcByte[{cmd.srcField, 1'b0} +: 2];
    nibBits  = srcByte[{cmd.srcField[0], 2'b00} +: 4];
    pairMask = 8'h03 << {cmd.dstField, 1'b0};
    nibMask  = 8'h0F << {cmd.dstField[0], 2'b00};
    pairVal  = {6'b0, pairBits} << {cmd.dstField, 1'b0};
    nibVal   = {4'b0, nibBits} << {cmd.dstField[0], 2'b00};

    unique case (cmd.kind)
      XF_BYTE:   merged = srcByte;
      XF_NIB:    merged = ~nibMask | nibVal;
      XF_PAIR:   merged = ~pairMask | pairVal;
      XF_DIRECT: merged = cmd.dataByte;
      default:   merged = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txByte <= 8'hFF;
      txSlot <= '0;
    end else begin
      txByte <= merged;
      txSlot <= wrSlot;
    end
  end

  // R3
  unassigned_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.kind == XF_NONE) |=> (txByte == 8'hFF));

  // R7
  direct_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.kind == XF_DIRECT) |=> (txByte == $past(cmd.dataByte)));

  // R4
  full_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.kind == XF_BYTE) |=> (txByte == $past(srcByte)));

  // R5
  nib_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.kind == XF_NIB) |=> ($countones(txByte) >= 4));

  // R6
  pair_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.kind == XF_PAIR) |=> ($countones(txByte) >= 6));

endmodule

// File: rtl/srs_switch.sv
module srs_switch
  import srs_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        rxByte,
  output logic [SLOT_W-1:0] slotNow,
  input  logic              cmWe,
  input  logic [SLOT_W-1:0] cmAddr,
  input  logic [3:0]        cmCode,
  input  logic [7:0]        cmData,
  input  logic [1:0]        cmPos,
  output logic [7:0]        txByte,
  output logic [SLOT_W-1:0] txSlot
);

  slotCmd_t          cmd;
  logic [SLOT_W-1:0] rdSlot;

  srs_ctrl #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmWe    (cmWe),
    .cmAddr  (cmAddr),
    .cmCode  (cmCode),
    .cmData  (cmData),
    .cmPos   (cmPos),
    .slotCnt (slotNow),
    .rdSlot  (rdSlot),
    .cmd     (cmd)
  );

  srs_datapath #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (cmd),
    .wrSlot (slotNow),
    .rdSlot (rdSlot),
    .rxByte (rxByte),
    .txByte (txByte),
    .txSlot (txSlot)
  );

endmodule

// File: tb/srs_switch_test.sv
module srs_switch_test;

  localparam int N      = 8;
  localparam int SW     = $clog2(N);
  localparam int FRAMES = 140;
  localparam int CYCLES = FRAMES * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    rxByte = 8'h00;
  logic [SW-1:0] slotNow;
  logic          cmWe = 1'b0;
  logic [SW-1:0] cmAddr = '0;
  logic [3:0]    cmCode = 4'h0;
  logic [7:0]    cmData = 8'h00;
  logic [1:0]    cmPos = 2'b00;
  logic [7:0]    txByte;
  logic [SW-1:0] txSlot;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  srs_switch #(.NUM_SLOTS(N)) uut (
    .clk(clk), .rst_n(rst_n), .rxByte(rxByte), .slotNow(slotNow),
    .cmWe(cmWe), .cmAddr(cmAddr), .cmCode(cmCode), .cmData(cmData),
    .cmPos(cmPos), .txByte(txByte), .txSlot(txSlot)
  );

  // Shadow model state
  int shCode [N];
  int shData [N];
  int shPos  [N];
  int prevBuf[N];
  int curBuf [N];

  task automatic checkVal(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int pat(input int c);
    return (c * 29 + (c >> 3) * 113 + 90) & 255;
  endfunction

  // Expected outgoing byte, computed arithmetically
  function automatic int expOut(input int code, input int data, input int pos,
                                input int src, output string tag);
    int f, d, s;
    if (code == 1) begin
      tag = "R4"; return src;
    end else if (code == 2 || code == 3) begin
      tag = "R5";
      s = (code == 3) ? 4 : 0;
      d = (pos >= 2) ? 4 : 0;
      f = (src / (1 << s)) % 16;
      return 255 - 15 * (1 << d) + f * (1 << d);
    end else if (code >= 4 && code <= 7) begin
      tag = "R6";
      s = 2 * (code - 4);
      d = 2 * pos;
      f = (src / (1 << s)) % 4;
      return 255 - 3 * (1 << d) + f * (1 << d);
    end else if (code == 9) begin
      tag = "R7"; return data;
    end
    tag = "R3";
    return 255;
  endfunction

  initial begin
    int pendByte, pendSlot;
    string pendTag;
    for (int i = 0; i < N; i++) begin
      shCode[i] = 0; shData[i] = 0; shPos[i] = 0;
      prevBuf[i] = 255; curBuf[i] = 255;
    end
    pendByte = 0; pendSlot = 0; pendTag = "";

    repeat (3) @(negedge clk);
    checkVal("R1 txByte", int'(txByte), 255);
    checkVal("R1 slotNow", int'(slotNow), 0);
    checkVal("R1 txSlot", int'(txSlot), 0);
    rst_n = 1'b1;

    for (int c = 0; c < CYCLES; c++) begin
      int k, a, cfg, code, src, tmp;
      string tg;
      if (c > 0) begin
        @(negedge clk);
        checkVal({pendTag, " R8 txByte"}, int'(txByte), pendByte);
        checkVal("R2 txSlot", int'(txSlot), pendSlot);
      end
      k = c % N;
      checkVal("R2 slotNow", int'(slotNow), k);

      // Expected result of this cycle, using the entries valid now (R9)
      code = shCode[k];
      src  = prevBuf[shData[k] % N];
      pendByte = expOut(code, shData[k], shPos[k], src, tg);
      pendTag  = tg;
      pendSlot = k;

      // Drive this cycle's inputs
      rxByte = 8'(pat(c));
      curBuf[k] = pat(c);
      a   = (c + 1) % N;
      cfg = c / N;
      cmWe   = (c % 11) != 10;
      cmAddr = SW'(a);
      cmCode = 4'((cfg + a * 5) % 16);
      cmPos  = 2'((cfg / 16 + a) % 4);
      cmData = 8'((c * 53 + 7) & 255);
      if (cmWe) begin
        shCode[a] = int'(cmCode);
        shData[a] = int'(cmData);
        shPos[a]  = int'(cmPos);
      end
      if (k == N - 1)
        for (int i = 0; i < N; i++) begin
          tmp = curBuf[i];
          prevBuf[i] = tmp;
        end
    end
    @(negedge clk);
    checkVal({pendTag, " R8 txByte"}, int'(txByte), pendByte);
    checkVal("R2 txSlot", int'(txSlot), pendSlot);
    cmWe = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule